// File: doc/BRIEF.md
# Ethernet Port Address Action Controller

This block sits beside the receive path of a single-port Ethernet address filter. Software programs three small control registers over a simple byte-wide register bus: a 6-bit port identifier, a configure register with a CRC-check enable, and a target register. The target register holds two 2-bit action codes, one for destination addresses and one for source addresses. The receive logic reports frame events to the block: a strobe when the destination address has been extracted, a strobe when the source address has been extracted, and a frame-end strobe. The frame-end strobe carries a CRC error flag and a 10 Mb/s speed indication.

For each destination address, the block either drops it or issues a one-cycle search request toward the address lookup memory. When the action code asks for it, the block also sets a sticky CPU interrupt flag. Software clears that flag by writing 1 to a status bit. The block captures each source address whose action code asks for learning and holds it until frame end, when the CRC result is known. It then issues a one-cycle learn request carrying the address and the port identifier. When the CRC check is enabled, a 10 Mb/s frame with a CRC error is not learned. At 100 Mb/s, or with the check disabled, the CRC flag has no effect.

Top module: `eth_port_action_ctrl`

## Requirements
- R1: After the synchronous reset, every register reads zero, so both address actions are "ignore". After reset, `da_search_req`, `sa_learn_req` and `cpu_irq` are low.
- R2: The port ID register sits at address CHIP_BASE+0x40. Bits 5:0 are stored and read back, and bits 7:6 always read 0.
- R3: The configure register sits at CHIP_BASE+0x41. Bit 1 is the CRC-check enable. All other bits are discarded on write and read 0.
- R4: The target register sits at CHIP_BASE+0x42. Bits 5:4 hold the DA action code and bits 7:6 hold the SA action code. Bits 3:0 are discarded on write and read 0.
- R5: A DA action code of 01 or 10 makes `da_search_req` pulse high for one cycle, on the clock edge after the cycle in which `da_valid` is high. `da_search_addr` then equals the strobed address. DA codes 00 and 11 produce no request.
- R6: DA action code 10 sets `cpu_irq` on the same edge as the search request. The flag stays high until software writes a byte with bit 0 set to the status register at CHIP_BASE+0x43. Writing 0 to that bit has no effect. Bit 0 of the status register reads the flag, and its other bits read 0.
- R7: An SA action code of 01 arms learning when `sa_valid` is high. The next `frame_end` then makes `sa_learn_req` pulse for one cycle on the following edge. The pulse carries the captured `sa_learn_addr` and the current port ID on `sa_learn_port`. SA codes 00, 10 and 11 produce no learn request.
- R8: A learn is vetoed exactly when, at `frame_end`, the CRC enable is 1, `speed_10` is 1 and `crc_err` is 1. A 100 Mb/s frame (`speed_10`=0) or a frame arriving with the check disabled is learned even when `crc_err` is 1.
- R9: `reg_rdata` updates on the edge after a cycle with `reg_rd_en` high. It reads 0 for any unmapped address, and it reads 0 in any cycle that follows one without `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| da_valid | input | 1 | Destination address extracted |
| da_addr | input | MAC_W | Extracted destination address |
| sa_valid | input | 1 | Source address extracted |
| sa_addr | input | MAC_W | Extracted source address |
| frame_end | input | 1 | End of frame, CRC result valid |
| crc_err | input | 1 | Frame had a CRC error (qualified by frame_end) |
| speed_10 | input | 1 | 1 = 10 Mb/s frame, 0 = 100 Mb/s |
| da_search_req | output | 1 | One-cycle DA search request |
| da_search_addr | output | MAC_W | Address to search |
| sa_learn_req | output | 1 | One-cycle SA learn request |
| sa_learn_addr | output | MAC_W | Address to learn |
| sa_learn_port | output | PID_W | Port ID attached to the learn |
| cpu_irq | output | 1 | Sticky DA interrupt flag |

## Verification
The bench builds the block with CHIP_BASE set to 0x80 rather than the default 0. This shows that the decode adds the base to each offset. It also lets a read of the bare offset 0x40 show that an unmapped address returns zero. ADDR_W stays at 8, and MAC_W and PID_W keep their defaults of 48 and 6. With these widths the bench can use full 48-bit address patterns and the all-ones port ID, which makes it visible that the upper register bits are dropped. All four codes of each action field are driven. Every combination of CRC enable, speed and CRC error that bears on the veto is driven as well.

// File: rtl/eth_pac_pkg.sv
package eth_pac_pkg;

  typedef enum logic [1:0] {
    DA_DROP      = 2'b00,
    DA_SEARCH    = 2'b01,
    DA_SEARCH_IR = 2'b10,
    DA_UNUSED    = 2'b11
  } da_act_e;

  typedef enum logic [1:0] {
    SA_DROP    = 2'b00,
    SA_LEARN   = 2'b01,
    SA_UNUSED2 = 2'b10,
    SA_UNUSED3 = 2'b11
  } sa_act_e;

  localparam int OFS_PID  = 'h40;
  localparam int OFS_CFG  = 'h41;
  localparam int OFS_TARG = 'h42;
  localparam int OFS_STAT = 'h43;

  localparam int CFG_CRC_BIT  = 1;
  localparam int TARG_DA_LSB  = 4;
  localparam int TARG_SA_LSB  = 6;
  localparam int STAT_IRQ_BIT = 0;

endpackage

// File: rtl/pac_regs.sv
module pac_regs
  import eth_pac_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PID_W     = 6,
  parameter int CHIP_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              irq_flag,
  output logic [7:0]        rdata,
  output logic [PID_W-1:0]  port_id,
  output logic              crc_en,
  output da_act_e           da_act,
  output sa_act_e           sa_act,
  output logic              irq_clr
);

  localparam logic [ADDR_W-1:0] A_PID  = ADDR_W'(CHIP_BASE + OFS_PID);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CHIP_BASE + OFS_CFG);
  localparam logic [ADDR_W-1:0] A_TARG = ADDR_W'(CHIP_BASE + OFS_TARG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CHIP_BASE + OFS_STAT);

  logic [1:0] da_q, sa_q;
  logic [7:0] rd_mux;

  assign da_act  = da_act_e'(da_q);
  assign sa_act  = sa_act_e'(sa_q);
  assign irq_clr = wr_en && (addr == A_STAT) && wdata[STAT_IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      port_id <= '0;
      crc_en  <= 1'b0;
      da_q    <= 2'b00;
      sa_q    <= 2'b00;
    end else if (wr_en) begin
      if (addr == A_PID)  port_id <= wdata[PID_W-1:0];
      if (addr == A_CFG)  crc_en  <= wdata[CFG_CRC_BIT];
      if (addr == A_TARG) begin
        da_q <= wdata[TARG_DA_LSB +: 2];
        sa_q <= wdata[TARG_SA_LSB +: 2];
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == A_PID) begin
      rd_mux[PID_W-1:0] = port_id;
    end else if (addr == A_CFG) begin
      rd_mux[CFG_CRC_BIT] = crc_en;
    end else if (addr == A_TARG) begin
      rd_mux[TARG_DA_LSB +: 2] = da_q;
      rd_mux[TARG_SA_LSB +: 2] = sa_q;
    end else if (addr == A_STAT) begin
      rd_mux[STAT_IRQ_BIT] = irq_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= 8'h00;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == 8'h00)); // R9

  AST_PID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == A_PID) |-> (rdata[7:PID_W] == '0)); // R2

  AST_TARG_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == A_TARG) |-> (rdata[3:0] == 4'h0)); // R4

endmodule

// File: rtl/pac_da_path.sv
module pac_da_path
  import eth_pac_pkg::*;
#(
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             da_valid,
  input  logic [MAC_W-1:0] da_addr,
  input  da_act_e          da_act,
  input  logic             irq_clr,
  output logic             search_req,
  output logic [MAC_W-1:0] search_addr,
  output logic             irq
);

  logic take, raise;

  assign take  = da_valid && (da_act == DA_SEARCH || da_act == DA_SEARCH_IR);
  assign raise = da_valid && (da_act == DA_SEARCH_IR);

  always_ff @(posedge clk) begin
    if (rst) begin
      search_req  <= 1'b0;
      search_addr <= '0;
      irq         <= 1'b0;
    end else begin
      search_req <= take;
      if (take) search_addr <= da_addr;
      if (raise)        irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  AST_DA_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    search_req |-> $past(da_valid)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(irq) && !$past(irq_clr)) |-> irq); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(da_valid) && search_req)); // R6

endmodule

// File: rtl/pac_sa_path.sv
module pac_sa_path
  import eth_pac_pkg::*;
#(
  parameter int MAC_W = 48,
  parameter int PID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sa_valid,
  input  logic [MAC_W-1:0] sa_addr,
  input  sa_act_e          sa_act,
  input  logic             frame_end,
  input  logic             crc_err,
  input  logic             speed_10,
  input  logic             crc_en,
  input  logic [PID_W-1:0] port_id,
  output logic             learn_req,
  output logic [MAC_W-1:0] learn_addr,
  output logic [PID_W-1:0] learn_port
);

  logic             pending;
  logic [MAC_W-1:0] held;
  logic             accept, veto;

  assign accept = sa_valid && (sa_act == SA_LEARN);
  assign veto   = crc_en && speed_10 && crc_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      held       <= '0;
      learn_req  <= 1'b0;
      learn_addr <= '0;
      learn_port <= '0;
    end else begin
      learn_req <= 1'b0;
      if (frame_end) begin
        pending <= 1'b0;
        if ((pending || accept) && !veto) begin
          learn_req  <= 1'b1;
          learn_addr <= accept ? sa_addr : held;
          learn_port <= port_id;
        end
      end else if (accept) begin
        pending <= 1'b1;
        held    <= sa_addr;
      end
    end
  end

  AST_SA_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    learn_req |-> $past(frame_end)); // R7

  AST_SA_CRC_VETO: assert property (@(posedge clk) disable iff (rst)
    learn_req |-> !($past(crc_en) && $past(speed_10) && $past(crc_err))); // R8

  AST_SA_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    learn_req |=> !learn_req || $past(frame_end)); // R7

endmodule

// File: rtl/eth_port_action_ctrl.sv
module eth_port_action_ctrl
  import eth_pac_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAC_W     = 48,
  parameter int PID_W     = 6,
  parameter int CHIP_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              da_valid,
  input  logic [MAC_W-1:0]  da_addr,
  input  logic              sa_valid,
  input  logic [MAC_W-1:0]  sa_addr,
  input  logic              frame_end,
  input  logic              crc_err,
  input  logic              speed_10,
  output logic              da_search_req,
  output logic [MAC_W-1:0]  da_search_addr,
  output logic              sa_learn_req,
  output logic [MAC_W-1:0]  sa_learn_addr,
  output logic [PID_W-1:0]  sa_learn_port,
  output logic              cpu_irq
);

  logic [PID_W-1:0] port_id;
  logic             crc_en;
  da_act_e          da_act;
  sa_act_e          sa_act;
  logic             irq_clr;

  pac_regs #(
    .ADDR_W(ADDR_W), .PID_W(PID_W), .CHIP_BASE(CHIP_BASE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .irq_flag(cpu_irq), .rdata(reg_rdata),
    .port_id(port_id), .crc_en(crc_en), .da_act(da_act), .sa_act(sa_act),
    .irq_clr(irq_clr)
  );

  pac_da_path #(.MAC_W(MAC_W)) u_da (
    .clk(clk), .rst(rst),
    .da_valid(da_valid), .da_addr(da_addr), .da_act(da_act), .irq_clr(irq_clr),
    .search_req(da_search_req), .search_addr(da_search_addr), .irq(cpu_irq)
  );

  pac_sa_path #(.MAC_W(MAC_W), .PID_W(PID_W)) u_sa (
    .clk(clk), .rst(rst),
    .sa_valid(sa_valid), .sa_addr(sa_addr), .sa_act(sa_act),
    .frame_end(frame_end), .crc_err(crc_err), .speed_10(speed_10),
    .crc_en(crc_en), .port_id(port_id),
    .learn_req(sa_learn_req), .learn_addr(sa_learn_addr), .learn_port(sa_learn_port)
  );

  AST_NO_LEARN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sa_learn_req && !da_search_req && !cpu_irq)); // R1

endmodule

// File: tb/eth_port_action_ctrl_tb.sv
module eth_port_action_ctrl_tb;

  localparam int ADDR_W = 8;
  localparam int MAC_W  = 48;
  localparam int PID_W  = 6;
  localparam int BASE   = 'h80;
  localparam logic [7:0] A_PID  = 8'hC0;
  localparam logic [7:0] A_CFG  = 8'hC1;
  localparam logic [7:0] A_TARG = 8'hC2;
  localparam logic [7:0] A_STAT = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic da_valid = 0, sa_valid = 0, frame_end = 0, crc_err = 0, speed_10 = 0;
  logic [MAC_W-1:0] da_addr = '0, sa_addr = '0;
  logic da_search_req, sa_learn_req, cpu_irq;
  logic [MAC_W-1:0] da_search_addr, sa_learn_addr;
  logic [PID_W-1:0] sa_learn_port;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  eth_port_action_ctrl #(
    .ADDR_W(ADDR_W), .MAC_W(MAC_W), .PID_W(PID_W), .CHIP_BASE(BASE)
  ) u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .da_valid(da_valid), .da_addr(da_addr), .sa_valid(sa_valid), .sa_addr(sa_addr),
    .frame_end(frame_end), .crc_err(crc_err), .speed_10(speed_10),
    .da_search_req(da_search_req), .da_search_addr(da_search_addr),
    .sa_learn_req(sa_learn_req), .sa_learn_addr(sa_learn_addr),
    .sa_learn_port(sa_learn_port), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "da_search_req", da_search_req, 0);
    chk("R1", "sa_learn_req", sa_learn_req, 0);
    chk("R1", "cpu_irq", cpu_irq, 0);
    rd(A_PID, d);  chk("R1", "pid", d, 0);
    rd(A_CFG, d);  chk("R1", "cfg", d, 0);
    rd(A_TARG, d); chk("R1", "targ", d, 0);
    rd(A_STAT, d); chk("R1", "stat", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_PID, 8'hFF);  rd(A_PID, d);  chk("R2", "pid all ones", d, 8'h3F);
    wr(A_PID, 8'h15);  rd(A_PID, d);  chk("R2", "pid pattern", d, 8'h15);
    wr(A_CFG, 8'hFF);  rd(A_CFG, d);  chk("R3", "cfg all ones", d, 8'h02);
    wr(A_CFG, 8'hFD);  rd(A_CFG, d);  chk("R3", "cfg bit1 clear", d, 8'h00);
    wr(A_TARG, 8'hFF); rd(A_TARG, d); chk("R4", "targ all ones", d, 8'hF0);
    wr(A_TARG, 8'h6A); rd(A_TARG, d); chk("R4", "targ pattern", d, 8'h60);
    rd(8'h40, d); chk("R9", "bare offset unmapped", d, 0);
    rd(8'hC4, d); chk("R9", "unmapped C4", d, 0);
    rd(A_TARG, d);
    @(negedge clk); chk("R9", "idle rdata", reg_rdata, 0);
    wr(A_TARG, 8'h00);
  endtask

  task automatic da_pulse(input logic [MAC_W-1:0] a, input bit exp_req,
                          input bit exp_irq, input string req);
    @(negedge clk);
    da_valid = 1; da_addr = a;
    @(negedge clk);
    da_valid = 0; da_addr = '0;
    chk(req, "da_search_req", da_search_req, exp_req);
    if (exp_req) chk(req, "da_search_addr", da_search_addr, a);
    chk("R6", "cpu_irq after da", cpu_irq, exp_irq);
    @(negedge clk);
    chk(req, "da_search_req pulse end", da_search_req, 0);
  endtask

  task automatic t_da();
    logic [7:0] d;
    wr(A_TARG, 8'h00); da_pulse(48'h0011_2233_4455, 0, 0, "R5");
    wr(A_TARG, 8'h10); da_pulse(48'hA1B2_C3D4_E5F6, 1, 0, "R5");
    wr(A_TARG, 8'h30); da_pulse(48'h1234_5678_9ABC, 0, 0, "R5");
    wr(A_TARG, 8'h20); da_pulse(48'hFEDC_BA98_7654, 1, 1, "R6");
    repeat (3) @(negedge clk);
    chk("R6", "irq sticky", cpu_irq, 1);
    rd(A_STAT, d); chk("R6", "stat reads flag", d, 8'h01);
    wr(A_STAT, 8'hFE);
    @(negedge clk); chk("R6", "write 0 keeps irq", cpu_irq, 1);
    wr(A_STAT, 8'h01);
    chk("R6", "write 1 clears irq", cpu_irq, 0);
    rd(A_STAT, d); chk("R6", "stat after clear", d, 8'h00);
    wr(A_TARG, 8'h10); da_pulse(48'h0000_0000_0001, 1, 0, "R6");
  endtask

  task automatic frame(input logic [MAC_W-1:0] a, input bit err, input bit s10,
                       input bit exp, input logic [PID_W-1:0] pid, input string req);
    @(negedge clk);
    sa_valid = 1; sa_addr = a;
    @(negedge clk);
    sa_valid = 0; sa_addr = '0;
    @(negedge clk);
    frame_end = 1; crc_err = err; speed_10 = s10;
    @(negedge clk);
    frame_end = 0; crc_err = 0; speed_10 = 0;
    chk(req, "sa_learn_req", sa_learn_req, exp);
    if (exp) begin
      chk(req, "sa_learn_addr", sa_learn_addr, a);
      chk(req, "sa_learn_port", sa_learn_port, pid);
    end
    @(negedge clk);
    chk(req, "sa_learn_req pulse end", sa_learn_req, 0);
  endtask

  task automatic t_sa();
    wr(A_PID, 8'h2A);
    wr(A_TARG, 8'h00); frame(48'h0102_0304_0506, 0, 0, 0, 6'h2A, "R7");
    wr(A_TARG, 8'h80); frame(48'h0102_0304_0507, 0, 0, 0, 6'h2A, "R7");
    wr(A_TARG, 8'hC0); frame(48'h0102_0304_0508, 0, 0, 0, 6'h2A, "R7");
    wr(A_TARG, 8'h40); frame(48'hDEAD_BEEF_0001, 0, 1, 1, 6'h2A, "R7");
    wr(A_PID, 8'h3F);  frame(48'hDEAD_BEEF_0002, 0, 0, 1, 6'h3F, "R7");
    wr(A_CFG, 8'h00);  frame(48'h5555_AAAA_0003, 1, 1, 1, 6'h3F, "R8");
    wr(A_CFG, 8'h02);  frame(48'h5555_AAAA_0004, 1, 1, 0, 6'h3F, "R8");
    frame(48'h5555_AAAA_0005, 1, 0, 1, 6'h3F, "R8");
    frame(48'h5555_AAAA_0006, 0, 1, 1, 6'h3F, "R8");
    frame(48'h5555_AAAA_0007, 0, 0, 1, 6'h3F, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_da();
    t_sa();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule